// File: doc/BRIEF.md
# Multiplexed Boot ROM Port Controller

This block lets an on-chip host reach an external byte-wide boot ROM, or a byte-wide external register, over a narrow shared bus. The host presents one request at a time: a read/write flag, an 18-bit byte address and, for writes, one data byte. The controller then runs a fixed three-phase access on the pins. Two address phases come first. Each sends part of the address, plus the ROM control levels, over the same 8 lines that later carry data, and a strobe loads each part into an external latch. A data phase follows, during which the chip enable is active. The controller then returns the read byte together with a one-clock completion pulse.

Two address-space settings are supported. In the 64 KB setting only address bits [15:0] leave the chip. In the 256 KB setting, bits 16 and 17 are sent one after the other on a spare address pin, one in each address phase. The length of every phase is the parameter `CYCLE_CLKS`, which defaults to 4 clocks. The shared bus is presented as separate in, out and output-enable signals, so that a pad ring can build the bidirectional pin.

The controller has five states: `IDLE`, `ADR_LO`, `ADR_HI`, `XFER` and `FIN`. It takes these transitions:
- `IDLE`→`ADR_LO` on `req_valid`; the request is captured at this point.
- `ADR_LO`→`ADR_HI` on the last clock of that phase.
- `ADR_HI`→`XFER` on the last clock of that phase.
- `XFER`→`FIN` on the last clock of that phase; read data is captured at this point.
- `FIN`→`IDLE` unconditionally.

Top module: `brom_port_ctrl`

## Requirements
- R1: In idle, and after reset, `rom_ce_n` is 1, `rom_ad_oe` is 0, `rom_a` is 0 and `done` is 0.
- R2: An accepted request runs `ADR_LO`, `ADR_HI` and `XFER`, each `CYCLE_CLKS` clocks long, then asserts `done` for exactly one clock. With the default of 4, `done` is high in the 13th clock after the accepting edge.
- R3: During `ADR_LO` the bus is driven and carries the following:
  - lines [7:2]: address bits [7:2];
  - line 1: output-enable, active low (0 for a read);
  - line 0: write-enable, active low (0 for a write).
- R4: During `ADR_HI` the bus is driven and carries address bits [15:8] on lines [7:0].
- R5: `rom_a[1]` is the latch strobe. It is high for exactly one clock in each address phase, at clock index `CYCLE_CLKS/2` counting from 0, and low at all other times.
- R6: With `wide_map`=1, `rom_a[0]` carries address bit 16 during `ADR_LO` and address bit 17 during `ADR_HI`. With `wide_map`=0, `rom_a[0]` stays 0. `wide_map` is sampled when the request is accepted.
- R7: `rom_ce_n` is low exactly during the `CYCLE_CLKS` clocks of `XFER`.
- R8: On a write, the bus is driven with the request's data byte throughout `XFER`.
- R9: On a read, the bus is released during `XFER`. `rom_ad_in` is sampled on the last clock of `XFER` and shows on `rd_data` while `done` is high.
- R10: A request presented while an access is in progress is ignored. The access in flight keeps its captured address and data, and no second access starts unless `req_valid` is still high in `IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present (taken only in IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Byte address |
| req_wdata | input | 8 | Write data byte |
| wide_map | input | 1 | 1 = 256 KB setting, 0 = 64 KB setting |
| rd_data | output | 8 | Captured read byte |
| done | output | 1 | One-clock completion pulse |
| rom_ad_out | output | 8 | Shared bus, outgoing value |
| rom_ad_oe | output | 1 | Shared bus drive enable |
| rom_ad_in | input | 8 | Shared bus, incoming value |
| rom_a | output | 2 | [1] latch strobe, [0] upper address bit |
| rom_ce_n | output | 1 | ROM / external register enable, active low |

## Verification
The hardest case to reach from the ports is a new request that arrives while an access is still in flight. Both the address latches and the data phase must keep the first request's values, and no extra access may follow. The stimulus therefore raises `req_valid` with a different address during `ADR_HI` and drops it before `done`. It then checks the latched values and the idle clocks that follow. A sweep of walking-one addresses and mixed address patterns, covering both address settings and both directions, shows every address bit appearing on exactly one line in the right phase.

// File: rtl/brom_pkg.sv
package brom_pkg;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        IDLE   = 3'd0,
        ADR_LO = 3'd1,
        ADR_HI = 3'd2,
        XFER   = 3'd3,
        FIN    = 3'd4
    } brom_state_e;
endpackage

// File: rtl/brom_phase_timer.sv
module brom_phase_timer #(
    parameter int CYCLE_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last,
    output logic mid
);
    localparam int CW  = (CYCLE_CLKS > 2) ? $clog2(CYCLE_CLKS) : 1;
    localparam int MID = CYCLE_CLKS / 2;
    localparam logic [CW-1:0] LAST_V = CW'(CYCLE_CLKS - 1);
    localparam logic [CW-1:0] MID_V  = CW'(MID);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == LAST_V) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last = run && (cnt_q == LAST_V);
    assign mid  = run && (cnt_q == MID_V);
endmodule

// File: rtl/brom_bus_mux.sv
module brom_bus_mux
    import brom_pkg::*;
(
    input  brom_state_e       phase,
    input  logic              wr,
    input  logic              wide,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              hi_bit
);
    always_comb begin
        bus_out = '0;
        bus_oe  = 1'b0;
        hi_bit  = 1'b0;
        unique case (phase)
            ADR_LO: begin
                // line 1: output-enable (active low), line 0: write-enable (active low)
                bus_out = {addr[7:2], wr, ~wr};
                bus_oe  = 1'b1;
                hi_bit  = wide & addr[16];
            end
            ADR_HI: begin
                bus_out = addr[15:8];
                bus_oe  = 1'b1;
                hi_bit  = wide & addr[17];
            end
            XFER: begin
                bus_out = wr ? wdata : '0;
                bus_oe  = wr;
            end
            IDLE, FIN: begin
                bus_out = '0;
                bus_oe  = 1'b0;
            end
            default: begin
                bus_out = '0;
                bus_oe  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/brom_port_ctrl.sv
module brom_port_ctrl
    import brom_pkg::*;
#(
    parameter int CYCLE_CLKS = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [17:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        wide_map,
    output logic [7:0]  rd_data,
    output logic        done,
    output logic [7:0]  rom_ad_out,
    output logic        rom_ad_oe,
    input  logic [7:0]  rom_ad_in,
    output logic [1:0]  rom_a,
    output logic        rom_ce_n
);
    brom_state_e state_q, state_d;

    logic              wr_q;
    logic              wide_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              run;
    logic              ph_last;
    logic              ph_mid;
    logic              hi_bit;

    assign run = (state_q == ADR_LO) || (state_q == ADR_HI) || (state_q == XFER);

    brom_phase_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .last  (ph_last),
        .mid   (ph_mid)
    );

    brom_bus_mux u_mux (
        .phase   (state_q),
        .wr      (wr_q),
        .wide    (wide_q),
        .addr    (addr_q),
        .wdata   (wdata_q),
        .bus_out (rom_ad_out),
        .bus_oe  (rom_ad_oe),
        .hi_bit  (hi_bit)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (req_valid) state_d = ADR_LO;
            ADR_LO:  if (ph_last)   state_d = ADR_HI;
            ADR_HI:  if (ph_last)   state_d = XFER;
            XFER:    if (ph_last)   state_d = FIN;
            FIN:                    state_d = IDLE;
            default:                state_d = IDLE;
        endcase
    end

    // state register and captured request / read byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IDLE;
            wr_q    <= 1'b0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == IDLE && req_valid) begin
                wr_q    <= req_write;
                wide_q  <= wide_map;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == XFER && ph_last && !wr_q) begin
                rdata_q <= rom_ad_in;
            end
        end
    end

    // outputs
    always_comb begin
        rom_ce_n = 1'b1;
        done     = 1'b0;
        rom_a    = 2'b00;
        unique case (state_q)
            ADR_LO, ADR_HI: rom_a = {ph_mid, hi_bit};
            XFER:           rom_ce_n = 1'b0;
            FIN:            done = 1'b1;
            IDLE:           rom_a = 2'b00;
            default:        rom_a = 2'b00;
        endcase
    end

    assign rd_data = rdata_q;
endmodule

// File: rtl/brom_port_sva.sv
module brom_port_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       done,
    input logic [1:0] rom_a,
    input logic       rom_ce_n,
    input logic       rom_ad_oe,
    input logic [7:0] rom_ad_out
);
    // R2: completion is a single-clock pulse
    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: completion directly follows the enabled data phase
    assert_done_after_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(rom_ce_n));

    // R1: chip enable is inactive and bus released while completing
    assert_done_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rom_ce_n && !rom_ad_oe && rom_a == 2'b00));

    // R5: strobe lasts one clock
    assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_a[1] |=> !rom_a[1]);

    // R3: strobe only while address is being driven, never with enable
    assert_strobe_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rom_a[1] |-> (rom_ad_oe && rom_ce_n));

    // R7: upper address pin quiet while enabled
    assert_ce_no_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_ce_n |-> (rom_a == 2'b00));

    // R8: bus direction and value steady through the data phase
    assert_xfer_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !$past(rom_ce_n)) |-> ($stable(rom_ad_oe) && $stable(rom_ad_out)));
endmodule

bind brom_port_ctrl brom_port_sva u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .rom_a      (rom_a),
    .rom_ce_n   (rom_ce_n),
    .rom_ad_oe  (rom_ad_oe),
    .rom_ad_out (rom_ad_out)
);

// File: tb/tb_brom_port_ctrl.sv
`timescale 1ns/1ps
module tb_brom_port_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        wide_map = 1'b0;
    logic [7:0]  rd_data;
    logic        done;
    logic [7:0]  rom_ad_out;
    logic        rom_ad_oe;
    logic [7:0]  rom_ad_in = 8'hC3;
    logic [1:0]  rom_a;
    logic        rom_ce_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    brom_port_ctrl #(.CYCLE_CLKS(4)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wide_map(wide_map),
        .rd_data(rd_data), .done(done), .rom_ad_out(rom_ad_out),
        .rom_ad_oe(rom_ad_oe), .rom_ad_in(rom_ad_in), .rom_a(rom_a),
        .rom_ce_n(rom_ce_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rom_byte(input logic [17:0] a);
        return 8'((a[7:0] ^ a[15:8]) + {6'b0, a[17:16]} + 8'h11);
    endfunction

    // one access; caller is at a negedge. disturb: raise a foreign request mid-access
    task automatic access(input bit wr, input logic [17:0] a, input logic [7:0] wd,
                          input bit wide, input bit disturb);
        logic [7:0] lat1 = '0, lat2 = '0;
        logic       a0_1 = 1'b0, a0_2 = 1'b0;
        int         nstb = 0, nce = 0, ndone = 0, bad_pos = 0;
        logic [7:0] exp1 = {a[7:2], wr, ~wr};
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; wide_map = wide;
        rom_ad_in = rom_byte(a);
        for (int s = 1; s <= 17; s++) begin
            @(negedge clk);
            if (s == 1) req_valid = 1'b0;
            if (disturb && s == 5) begin
                req_valid = 1'b1; req_write = ~wr; req_addr = ~a; req_wdata = ~wd;
                wide_map = ~wide;
            end
            if (disturb && s == 10) req_valid = 1'b0;
            if (rom_a[1]) begin
                nstb++;
                if (s != 3 && s != 7) bad_pos++;
                if (nstb == 1) begin lat1 = rom_ad_out; a0_1 = rom_a[0]; end
                if (nstb == 2) begin lat2 = rom_ad_out; a0_2 = rom_a[0]; end
                chk(rom_ad_oe, "R3 bus driven at strobe", rom_ad_oe, 1);
            end
            if (!rom_ce_n) begin
                nce++;
                if (s < 9 || s > 12) bad_pos++;
                chk(rom_ad_oe == wr, wr ? "R8 bus driven in data" : "R9 bus released in data",
                    rom_ad_oe, wr);
                if (wr) chk(rom_ad_out == wd, "R8 write byte", rom_ad_out, wd);
            end
            if (done) begin
                ndone++;
                chk(s == 13, "R2 done timing", s, 13);
                if (!wr) chk(rd_data == rom_byte(a), "R9 read byte", rd_data, rom_byte(a));
            end
            if (s >= 14) begin
                chk(rom_ce_n && !rom_ad_oe && rom_a == 2'b00 && !done,
                    disturb ? "R10 no second access" : "R1 idle after done",
                    {rom_ce_n, rom_ad_oe, rom_a, done}, 5'b10000);
            end
        end
        chk(nstb == 2, "R5 strobe count", nstb, 2);
        chk(bad_pos == 0, "R5 R7 strobe/enable position", bad_pos, 0);
        chk(nce == 4, "R7 enable length", nce, 4);
        chk(ndone == 1, "R2 single done", ndone, 1);
        chk(lat1 == exp1, disturb ? "R10 first latch kept" : "R3 first latch", lat1, exp1);
        chk(lat2 == a[15:8], disturb ? "R10 second latch kept" : "R4 second latch", lat2, a[15:8]);
        chk(a0_1 == (wide & a[16]), "R6 bit16 on first phase", a0_1, wide & a[16]);
        chk(a0_2 == (wide & a[17]), "R6 bit17 on second phase", a0_2, wide & a[17]);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rom_ce_n && !rom_ad_oe && rom_a == 2'b00 && !done, "R1 reset state",
            {rom_ce_n, rom_ad_oe, rom_a, done}, 5'b10000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rom_ce_n && !rom_ad_oe && rom_a == 2'b00 && !done, "R1 idle state",
            {rom_ce_n, rom_ad_oe, rom_a, done}, 5'b10000);
        // walking-one and walking-zero addresses, both settings, both directions
        for (int w = 0; w < 2; w++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 18; i++) begin
                    access(d[0], 18'(1) << i, 8'(8'h5A ^ i), w[0], 1'b0);
                    access(d[0], ~(18'(1) << i), 8'(8'hA5 + i), w[0], 1'b0);
                end
        // mixed patterns
        for (int k = 0; k < 48; k++)
            access(k[0], 18'(k * 32'h2D4B7), 8'(k * 37), k[1], 1'b0);
        // R10: requests during an access are ignored
        access(1'b0, 18'h2_9C64, 8'h00, 1'b1, 1'b1);
        access(1'b1, 18'h1_36A8, 8'h7E, 1'b1, 1'b1);
        access(1'b0, 18'h0_F00F, 8'h00, 1'b0, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule